// File: doc/BRIEF.md
# Programmable Output Clock Divider

The block takes a fast source clock and divides it by one of thirteen fixed ratios, odd ones among them. A 4-bit code selects the ratio. The divided output stays close to 50 % duty at every ratio. For odd ratios, a phase captured on the rising edge is widened by half a source cycle, using a copy of it taken on the falling edge.

A new ratio takes effect only when the current output period ends, so no short pulse ever appears. The divided clock has its own enable, and this enable only opens or closes while the divided clock is low. A second path drives a reference output: either the incoming reference as it is, or that reference divided by two. The reference output has its own enable.

A tristate request pulls down the shared pad output-enable. A power-down request stops both outputs, holds the divider counter, and drops the pad enable. When power-down is released, the divider restarts with a full first pulse.

Top module: `clk_out_div`

## Requirements
- R1: Code values 0 to 12 select, in ascending order, the ratios 2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 18, 24 and 30. The period of `div_clk_o` is then that ratio times the source period.
- R2: At every ratio N, `div_clk_o` is high for exactly N half-periods of the source clock, which is 50 % duty. Odd ratios get this by widening the phase by half a cycle.
- R3: Codes 13, 14 and 15 select a ratio of 2.
- R4: A ratio change made in the middle of an output period does not shorten that period. The old high and low phases both complete at full width, and the new ratio starts at the next rising edge of the output.
- R5: Dropping `enable_i` lets the current high pulse finish at full width, and the output then stays low. Raising `enable_i` makes the first visible pulse a full-width one.
- R6: While `ref_en_i` is low, `ref_clk_o` stays low.
- R7: With `ref_half_i` low, `ref_clk_o` follows `ref_clk_i`. With `ref_half_i` high, `ref_clk_o` changes level once for every rising edge of `ref_clk_i`, which divides it by two.
- R8: While `tristate_i` is high, `pad_oe_o` is low. The divider keeps running, and `pad_oe_o` returns high when `tristate_i` is released.
- R9: While `pwrdn_i` is high, `div_clk_o`, `ref_clk_o` and `pad_oe_o` are low. After release, the first pulse of `div_clk_o` has full width and the period matches the selected ratio.
- R10: During reset `div_clk_o` is low. After reset, code 0 divides by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_code_i | input | 4 | Ratio select code, synchronous to clk_i |
| enable_i | input | 1 | Enable for the divided output |
| tristate_i | input | 1 | Request to float the pads |
| pwrdn_i | input | 1 | Power-down request |
| ref_clk_i | input | 1 | Reference clock input |
| ref_en_i | input | 1 | Enable for the reference output |
| ref_half_i | input | 1 | High selects reference divided by two |
| div_clk_o | output | 1 | Divided clock |
| ref_clk_o | output | 1 | Reference output clock |
| pad_oe_o | output | 1 | Output enable for the clock pads |

## Verification
Every ratio code is tried in turn, and both the high time and the period of the output are measured. This separates a wrong table entry from a duty-cycle fault, and odd ratios are the ones that expose a missing half-cycle extension. Ratio changes and enable toggles are made in the middle of a long high phase, and the pulse widths around each change are measured, so that a change applied immediately stands out from one deferred to the period end. The reference path is sampled away from its edges in both the copy and the halving modes. Power-down is applied during running operation, and the first pulse after release is measured.

// File: rtl/clk_div_pkg.sv
`timescale 1ns/1ps
package clk_div_pkg;
  localparam int CODE_W    = 4;
  localparam int MAX_RATIO = 30;

  // ascending ratio set; spare codes fall back to 2
  function automatic int unsigned ratio_of(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    return 2;
      4'd1:    return 3;
      4'd2:    return 4;
      4'd3:    return 5;
      4'd4:    return 6;
      4'd5:    return 8;
      4'd6:    return 9;
      4'd7:    return 10;
      4'd8:    return 12;
      4'd9:    return 15;
      4'd10:   return 18;
      4'd11:   return 24;
      4'd12:   return 30;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/div_core.sv
`timescale 1ns/1ps
module div_core import clk_div_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrdn_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              raw_o
);
  localparam int CNT_W = $clog2(MAX_RATIO + 1);

  logic [CNT_W-1:0] n_sel, n_q, cnt_q;
  logic             p_q, p_neg_q, odd_q, wrap;

  assign n_sel = CNT_W'(ratio_of(code_i));
  assign wrap  = (cnt_q == n_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= CNT_W'(2);
      cnt_q <= CNT_W'(1);
      p_q   <= 1'b0;
      odd_q <= 1'b0;
    end else if (pwrdn_i) begin
      // park on last count so release starts a fresh period
      n_q   <= n_sel;
      cnt_q <= n_sel - CNT_W'(1);
      p_q   <= 1'b0;
      odd_q <= n_sel[0];
    end else if (wrap) begin
      n_q   <= n_sel;
      cnt_q <= '0;
      p_q   <= 1'b1;
      odd_q <= n_sel[0];
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      p_q   <= (cnt_q + CNT_W'(1)) < (n_q >> 1);
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_neg_q <= 1'b0;
    else         p_neg_q <= p_q;
  end

  assign raw_o = odd_q ? (p_q | p_neg_q) : p_q;

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < n_q);
  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !pwrdn_i) |=> (cnt_q == '0));
  p_ratio_at_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(n_q) |-> (($past(cnt_q) == $past(n_q) - CNT_W'(1)) || $past(pwrdn_i)));
  p_pd_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_i |=> !p_q);
endmodule

// File: rtl/glitch_gate.sv
`timescale 1ns/1ps
module glitch_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic raw_i,
  output logic clk_o
);
  logic [SYNC_STAGES-1:0] en_s;
  logic                   gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_s <= '0;
    else         en_s <= {en_s[SYNC_STAGES-2:0], en_i};
  end

  // gate may only move while the divided clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gate_q <= 1'b0;
    else if (!raw_i) gate_q <= en_s[SYNC_STAGES-1];
  end

  assign clk_o = raw_i & gate_q;

  p_gate_quiet_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$stable(gate_q) |-> !$past(raw_i));
endmodule

// File: rtl/ref_path.sv
`timescale 1ns/1ps
module ref_path (
  input  logic ref_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic half_i,
  input  logic pwrdn_i,
  output logic ref_o
);
  logic tog_q;

  always_ff @(posedge ref_i or negedge rst_ni) begin
    if (!rst_ni)      tog_q <= 1'b0;
    else if (pwrdn_i) tog_q <= 1'b0;
    else              tog_q <= ~tog_q;
  end

  assign ref_o = (en_i && !pwrdn_i) ? (half_i ? tog_q : ref_i) : 1'b0;

  p_ref_pd_r9: assert property (@(posedge ref_i) disable iff (!rst_ni)
    pwrdn_i |=> !tog_q);
endmodule

// File: rtl/clk_out_div.sv
`timescale 1ns/1ps
module clk_out_div import clk_div_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] ratio_code_i,
  input  logic              enable_i,
  input  logic              tristate_i,
  input  logic              pwrdn_i,
  input  logic              ref_clk_i,
  input  logic              ref_en_i,
  input  logic              ref_half_i,
  output logic              div_clk_o,
  output logic              ref_clk_o,
  output logic              pad_oe_o
);
  logic raw;

  div_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwrdn_i (pwrdn_i),
    .code_i  (ratio_code_i),
    .raw_o   (raw)
  );

  glitch_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (enable_i & ~pwrdn_i),
    .raw_i  (raw),
    .clk_o  (div_clk_o)
  );

  ref_path u_ref (
    .ref_i   (ref_clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ref_en_i),
    .half_i  (ref_half_i),
    .pwrdn_i (pwrdn_i),
    .ref_o   (ref_clk_o)
  );

  assign pad_oe_o = ~tristate_i & ~pwrdn_i;
endmodule

// File: tb/clk_out_div_tb.sv
`timescale 1ns/1ps
module clk_out_div_tb;
  logic       clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic [3:0] code = 4'd0;
  logic       enable = 1'b0, tristate = 1'b0, pwrdn = 1'b0;
  logic       ref_en = 1'b0, ref_half = 1'b0;
  logic       div_clk, ref_out, pad_oe;

  int  total = 0, bad = 0;
  bit  done  = 0;
  int  rt [13] = '{2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 18, 24, 30};

  always #2.5 clk = ~clk;
  always #6   ref_clk = ~ref_clk;

  clk_out_div u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ratio_code_i(code), .enable_i(enable),
    .tristate_i(tristate), .pwrdn_i(pwrdn), .ref_clk_i(ref_clk),
    .ref_en_i(ref_en), .ref_half_i(ref_half), .div_clk_o(div_clk),
    .ref_clk_o(ref_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input string req, input string what, input real act, input real exp);
    total++;
    if (act > exp + 0.01 || act < exp - 0.01) begin
      bad++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic meas(output real hi, output real per);
    real t0, t1, t2;
    @(posedge div_clk); t0 = $realtime;
    @(negedge div_clk); t1 = $realtime;
    @(posedge div_clk); t2 = $realtime;
    hi = t1 - t0; per = t2 - t0;
  endtask

  task automatic set_code(input logic [3:0] c);
    @(negedge clk); code = c;
    @(posedge div_clk);
  endtask

  task automatic t_reset();
    real hi, per;
    #10;
    chk("R10", "div low in reset", real'(div_clk), 0.0);
    chk("R8", "oe high in reset", real'(pad_oe), 1.0);
    #12.1 rst_n = 1'b1;
    @(negedge clk); enable = 1'b1;
    @(posedge div_clk);
    meas(hi, per);
    chk("R10", "default period", per, 10.0);
  endtask

  task automatic t_ratios();
    real hi, per;
    for (int c = 0; c < 13; c++) begin
      set_code(4'(c));
      meas(hi, per);
      chk("R1", $sformatf("period code %0d", c), per, rt[c] * 5.0);
      chk("R2", $sformatf("high code %0d", c), hi, rt[c] * 2.5);
    end
  endtask

  task automatic t_unused();
    real hi, per;
    for (int c = 13; c < 16; c++) begin
      set_code(4'(c));
      meas(hi, per);
      chk("R3", $sformatf("period spare code %0d", c), per, 10.0);
    end
  endtask

  task automatic t_switch();
    real t0, t1, t2, hi, per;
    set_code(4'd12);
    @(posedge div_clk); t0 = $realtime;
    repeat (3) @(negedge clk);
    code = 4'd0;
    @(negedge div_clk); t1 = $realtime;
    @(posedge div_clk); t2 = $realtime;
    chk("R4", "old high kept", t1 - t0, 75.0);
    chk("R4", "old low kept", t2 - t1, 75.0);
    meas(hi, per);
    chk("R4", "new period", per, 10.0);
  endtask

  task automatic t_enable();
    real t0, t1;
    int  highs;
    set_code(4'd12);
    @(posedge div_clk); t0 = $realtime;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge div_clk); t1 = $realtime;
    chk("R5", "last pulse full", t1 - t0, 75.0);
    highs = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #0.3;
      if (div_clk) highs++;
    end
    chk("R5", "stays low when disabled", real'(highs), 0.0);
    enable = 1'b1;
    @(posedge div_clk); t0 = $realtime;
    @(negedge div_clk); t1 = $realtime;
    chk("R5", "first pulse full a", t1 - t0, 75.0);
    @(negedge clk); enable = 1'b0;
    repeat (100) @(negedge clk);
    repeat (7) @(negedge clk);
    enable = 1'b1;
    @(posedge div_clk); t0 = $realtime;
    @(negedge div_clk); t1 = $realtime;
    chk("R5", "first pulse full b", t1 - t0, 75.0);
  endtask

  task automatic t_tristate();
    real hi, per;
    @(negedge clk); tristate = 1'b1; #0.5;
    chk("R8", "oe low when tristated", real'(pad_oe), 0.0);
    meas(hi, per);
    chk("R8", "divider runs while tristated", per, 150.0);
    @(negedge clk); tristate = 1'b0; #0.5;
    chk("R8", "oe back high", real'(pad_oe), 1.0);
  endtask

  task automatic t_ref();
    int miss, flips;
    logic prev;
    ref_en = 1'b1; ref_half = 1'b0;
    miss = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #0.3;
      if (ref_out !== ref_clk) miss++;
    end
    chk("R7", "buffered copy mismatches", real'(miss), 0.0);
    ref_half = 1'b1;
    @(negedge ref_clk); #1 prev = ref_out;
    flips = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge ref_clk); #1;
      if (ref_out !== prev) flips++;
      prev = ref_out;
    end
    chk("R7", "halved output flips", real'(flips), 8.0);
    ref_en = 1'b0;
    miss = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #0.3;
      if (ref_out) miss++;
    end
    chk("R6", "ref low when disabled", real'(miss), 0.0);
  endtask

  task automatic t_pd();
    real t0, t1, hi, per;
    int  highs;
    set_code(4'd1);
    ref_en = 1'b1; ref_half = 1'b0;
    @(negedge clk); pwrdn = 1'b1;
    repeat (4) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 80; i++) begin
      #1.2;
      if (div_clk || ref_out) highs++;
    end
    chk("R9", "outputs low in power-down", real'(highs), 0.0);
    chk("R9", "oe low in power-down", real'(pad_oe), 0.0);
    @(negedge clk); pwrdn = 1'b0;
    @(posedge div_clk); t0 = $realtime;
    @(negedge div_clk); t1 = $realtime;
    chk("R9", "first pulse after release", t1 - t0, 7.5);
    meas(hi, per);
    chk("R9", "period after release", per, 15.0);
    ref_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL all watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_ratios();
    t_unused();
    t_switch();
    t_enable();
    t_tristate();
    t_ref();
    t_pd();
    finish_run();
  end
endmodule